// File: doc/BRIEF.md
# Small RISC Instruction Executor

This block is a multi-cycle processor core for a minimal 32-bit, word-addressed instruction set. It runs one instruction at a time: a fetch cycle reads the instruction word, an execute cycle decodes it, reads two registers and works out the result and the next program counter, and the two memory instructions take one further cycle to reach the data memory. The core stops when it executes a halt.

The architectural state is a program counter, eight 32-bit general registers and one external word memory reached through a single port. The memory answers a read combinationally from the address the core presents. It performs a write on the rising clock edge while the write strobe is high. The core reports whether it has halted, its program counter, and how many instructions it has completed.

Top module: `tiny_core`

## Requirements
- R1: While `rst` is high at a rising edge, the core clears the program counter, the instruction count, the halted flag and all eight registers to zero. It then starts fetching at address 0.
- R2: The instruction word fields are: opcode in bits 24:22, first source register in bits 21:19, second register in bits 18:16, R-type destination in bits 2:0, and a 16-bit immediate in bits 15:0. Opcode 0 writes the 32-bit sum of the two source registers to the destination. Opcode 1 writes the bitwise NOR of the two source registers to the destination.
- R3: Opcode 2 (load) reads memory at first register + sign-extended immediate and writes the word to the second register. Opcode 3 (store) writes the second register to that same address.
- R4: Opcode 4 (branch-if-equal) sets PC to PC + 1 + sign-extended immediate when both registers are equal, and to PC + 1 otherwise. Backward offsets are allowed.
- R5: Opcode 5 (jump-and-link) writes PC + 1 into the second register and sets PC to the value the first register held before that write. This holds when both fields name the same register.
- R6: Opcode 6 (halt) sets PC to PC + 1 and raises `halted`. After that, PC, the count and memory stay unchanged and `mem_we` stays low until reset.
- R7: `instr_count` rises by exactly one for every completed instruction, halt included. A branch skips instructions, and skipped instructions are not counted.
- R8: Instructions other than load and store take 2 clock cycles. Load and store take 3 clock cycles. `mem_we` is high only in the final cycle of a store.
- R9: Opcode 7 (no-op) only advances PC by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | ADDR_W (16) | Word address for fetch, load or store |
| mem_rdata | input | DATA_W (32) | Word read combinationally at `mem_addr` |
| mem_wdata | output | DATA_W (32) | Store data |
| mem_we | output | 1 | Store strobe, memory writes at the rising edge |
| halted | output | 1 | High once a halt has executed |
| pc | output | ADDR_W (16) | Current program counter |
| instr_count | output | CNT_W (32) | Completed-instruction count |

## Verification
Each result falls due at a fixed number of rising edges after reset release. The edge count is 2 per ordinary instruction and 3 per load or store. The bench therefore counts edges from reset release and samples on the falling edge. It expects the first load to retire after edge 3 and not after edge 2. For the test program, it expects `halted` at exactly edge 74. Register results are brought out by stores, and the bench reads the memory image only after the halt, when no further write can land.

// File: rtl/tc_pkg.sv
package tc_pkg;

    localparam int WORD_W  = 32;
    localparam int IMM_W   = 16;
    localparam int FIELD_W = 3;
    localparam int OPC_LSB = 22;
    localparam int RA_LSB  = 19;
    localparam int RB_LSB  = 16;
    localparam int RD_LSB  = 0;

    typedef enum logic [FIELD_W-1:0] {
        OP_ADD  = 3'd0,
        OP_NOR  = 3'd1,
        OP_LW   = 3'd2,
        OP_SW   = 3'd3,
        OP_BEQ  = 3'd4,
        OP_JALR = 3'd5,
        OP_HALT = 3'd6,
        OP_NOOP = 3'd7
    } opcode_e;

    typedef enum logic [1:0] {
        PH_FETCH,
        PH_EXEC,
        PH_MEM,
        PH_STOP
    } phase_e;

    typedef struct packed {
        opcode_e              op;
        logic [FIELD_W-1:0]   ra;
        logic [FIELD_W-1:0]   rb;
        logic [FIELD_W-1:0]   rd;
        logic [WORD_W-1:0]    imm;
    } dec_t;

    function automatic logic [WORD_W-1:0] widen_imm(input logic [IMM_W-1:0] v);
        return {{(WORD_W-IMM_W){v[IMM_W-1]}}, v};
    endfunction

endpackage

// File: rtl/tc_decode.sv
module tc_decode
    import tc_pkg::*;
#(
    parameter int DATA_W = WORD_W
) (
    input  logic [DATA_W-1:0] instr,
    output dec_t              dec
);
    always_comb begin
        dec.op  = opcode_e'(instr[OPC_LSB +: FIELD_W]);
        dec.ra  = instr[RA_LSB +: FIELD_W];
        dec.rb  = instr[RB_LSB +: FIELD_W];
        dec.rd  = instr[RD_LSB +: FIELD_W];
        dec.imm = widen_imm(instr[IMM_W-1:0]);
    end
endmodule

// File: rtl/tc_regfile.sv
module tc_regfile #(
    parameter int DATA_W = 32,
    parameter int NREG   = 8,
    localparam int AW    = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr_a,
    input  logic [AW-1:0]     raddr_b,
    output logic [DATA_W-1:0] rdata_a,
    output logic [DATA_W-1:0] rdata_b
);
    logic [DATA_W-1:0] bank [NREG];
    logic [NREG-1:0]   wsel;

    for (genvar g = 0; g < NREG; g++) begin : g_wsel
        assign wsel[g] = we && (waddr == AW'(g));
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NREG; i++) begin
            if (rst) begin
                bank[i] <= '0;
            end else if (wsel[i]) begin
                bank[i] <= wdata;
            end
        end
    end

    assign rdata_a = bank[raddr_a];
    assign rdata_b = bank[raddr_b];
endmodule

// File: rtl/tc_exec.sv
module tc_exec
    import tc_pkg::*;
#(
    parameter int DATA_W = WORD_W,
    parameter int ADDR_W = 16
) (
    input  dec_t              dec,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic [ADDR_W-1:0] pc,
    output logic [DATA_W-1:0] alu_res,
    output logic [DATA_W-1:0] link_val,
    output logic [ADDR_W-1:0] eff_addr,
    output logic [ADDR_W-1:0] pc_inc,
    output logic [ADDR_W-1:0] pc_next
);
    logic [DATA_W-1:0] sum_w;
    logic [DATA_W-1:0] nor_w;
    logic [DATA_W-1:0] ea_full;
    logic [ADDR_W-1:0] br_target;

    assign sum_w     = opa + opb;
    assign nor_w     = ~(opa | opb);
    assign ea_full   = opa + dec.imm;
    assign eff_addr  = ea_full[ADDR_W-1:0];
    assign pc_inc    = pc + 1'b1;
    assign br_target = pc_inc + dec.imm[ADDR_W-1:0];
    assign link_val  = DATA_W'(pc_inc);
    assign alu_res   = (dec.op == OP_NOR) ? nor_w : sum_w;

    always_comb begin
        case (dec.op)
            OP_BEQ:  pc_next = (opa == opb) ? br_target : pc_inc;
            OP_JALR: pc_next = opa[ADDR_W-1:0];
            default: pc_next = pc_inc;
        endcase
    end
endmodule

// File: rtl/tiny_core.sv
module tiny_core
    import tc_pkg::*;
#(
    parameter int DATA_W = WORD_W,
    parameter int ADDR_W = 16,
    parameter int NREG   = 8,
    parameter int CNT_W  = 32,
    localparam int RAW   = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              halted,
    output logic [ADDR_W-1:0] pc,
    output logic [CNT_W-1:0]  instr_count
);
    phase_e             phase_q, phase_d;
    logic [ADDR_W-1:0]  pc_q, pc_d;
    logic [DATA_W-1:0]  ir_q, ir_d;
    logic [ADDR_W-1:0]  ea_q, ea_d;
    logic [CNT_W-1:0]   cnt_q, cnt_d;

    dec_t               dec;
    logic [DATA_W-1:0]  rd_a, rd_b;
    logic               rf_we;
    logic [RAW-1:0]     rf_waddr;
    logic [DATA_W-1:0]  rf_wdata;
    logic [DATA_W-1:0]  alu_res, link_val;
    logic [ADDR_W-1:0]  eff_addr, pc_inc, pc_next;

    tc_decode #(.DATA_W(DATA_W)) u_dec (
        .instr (ir_q),
        .dec   (dec)
    );

    tc_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .we      (rf_we),
        .waddr   (rf_waddr),
        .wdata   (rf_wdata),
        .raddr_a (RAW'(dec.ra)),
        .raddr_b (RAW'(dec.rb)),
        .rdata_a (rd_a),
        .rdata_b (rd_b)
    );

    tc_exec #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_exe (
        .dec      (dec),
        .opa      (rd_a),
        .opb      (rd_b),
        .pc       (pc_q),
        .alu_res  (alu_res),
        .link_val (link_val),
        .eff_addr (eff_addr),
        .pc_inc   (pc_inc),
        .pc_next  (pc_next)
    );

    always_comb begin
        phase_d  = phase_q;
        pc_d     = pc_q;
        ir_d     = ir_q;
        ea_d     = ea_q;
        cnt_d    = cnt_q;
        rf_we    = 1'b0;
        rf_waddr = RAW'(dec.rd);
        rf_wdata = alu_res;
        mem_addr = pc_q;
        mem_we   = 1'b0;
        case (phase_q)
            PH_FETCH: begin
                ir_d    = mem_rdata;
                phase_d = PH_EXEC;
            end
            PH_EXEC: begin
                case (dec.op)
                    OP_ADD, OP_NOR: begin
                        rf_we   = 1'b1;
                        pc_d    = pc_next;
                        cnt_d   = cnt_q + 1'b1;
                        phase_d = PH_FETCH;
                    end
                    OP_LW, OP_SW: begin
                        ea_d    = eff_addr;
                        phase_d = PH_MEM;
                    end
                    OP_JALR: begin
                        rf_we    = 1'b1;
                        rf_waddr = RAW'(dec.rb);
                        rf_wdata = link_val;
                        pc_d     = pc_next;
                        cnt_d    = cnt_q + 1'b1;
                        phase_d  = PH_FETCH;
                    end
                    OP_HALT: begin
                        pc_d    = pc_inc;
                        cnt_d   = cnt_q + 1'b1;
                        phase_d = PH_STOP;
                    end
                    default: begin
                        pc_d    = pc_next;
                        cnt_d   = cnt_q + 1'b1;
                        phase_d = PH_FETCH;
                    end
                endcase
            end
            PH_MEM: begin
                mem_addr = ea_q;
                if (dec.op == OP_LW) begin
                    rf_we    = 1'b1;
                    rf_waddr = RAW'(dec.rb);
                    rf_wdata = mem_rdata;
                end else begin
                    mem_we = 1'b1;
                end
                pc_d    = pc_inc;
                cnt_d   = cnt_q + 1'b1;
                phase_d = PH_FETCH;
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_FETCH;
            pc_q    <= '0;
            ir_q    <= '0;
            ea_q    <= '0;
            cnt_q   <= '0;
        end else begin
            phase_q <= phase_d;
            pc_q    <= pc_d;
            ir_q    <= ir_d;
            ea_q    <= ea_d;
            cnt_q   <= cnt_d;
        end
    end

    assign mem_wdata   = rd_b;
    assign halted      = (phase_q == PH_STOP);
    assign pc          = pc_q;
    assign instr_count = cnt_q;
endmodule

// File: rtl/tiny_core_chk.sv
module tiny_core_chk #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              halted,
    input logic [ADDR_W-1:0] pc,
    input logic [CNT_W-1:0]  icount,
    input logic              mem_we
);
    p_halt_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    p_pc_frozen_r6: assert property (@(posedge clk) disable iff (rst)
        halted |=> $stable(pc));

    p_no_store_halted_r6: assert property (@(posedge clk) disable iff (rst)
        halted |-> !mem_we);

    p_count_frozen_r7: assert property (@(posedge clk) disable iff (rst)
        halted |=> $stable(icount));

    p_count_step_r7: assert property (@(posedge clk) disable iff (rst)
        !halted |=> (icount == $past(icount) || icount == $past(icount) + 1'b1));

    p_store_retires_r8: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> (icount == $past(icount) + 1'b1));
endmodule

bind tiny_core tiny_core_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .halted (halted),
    .pc     (pc),
    .icount (instr_count),
    .mem_we (mem_we)
);

// File: tb/tiny_core_test.sv
`timescale 1ns/1ps
module tiny_core_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] mem_addr;
    logic [31:0] mem_rdata, mem_wdata;
    logic        mem_we, halted;
    logic [15:0] pc;
    logic [31:0] instr_count;

    int checks = 0;
    int errors = 0;
    logic [31:0] mem [256];

    always #4 clk = ~clk;

    tiny_core uut (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .halted(halted),
        .pc(pc), .instr_count(instr_count)
    );

    assign mem_rdata = mem[mem_addr[7:0]];
    always @(posedge clk) if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;

    // expected memory image after halt: {address, value}
    localparam logic [39:0] EXPECT [10] = '{
        {8'd200, 32'hFFFF_FFFD}, {8'd201, 32'h0000_0002},
        {8'd202, 32'h0000_0005}, {8'd203, 32'h0000_0005},
        {8'd204, 32'hDEAD_BEEF}, {8'd205, 32'h0000_0000},
        {8'd206, 32'hDEAD_BEEF}, {8'd207, 32'd20},
        {8'd208, 32'hDEAD_BEEF}, {8'd209, 32'd26}
    };

    function automatic string tag_of(input int a);
        if (a <= 201) return "R2 add/nor";
        if (a == 202) return "R3 negative offset";
        if (a <= 205) return "R4 branch";
        return "R5 jump-and-link";
    endfunction

    function automatic logic [31:0] ei(input logic [2:0] op, input logic [2:0] a,
                                       input logic [2:0] b, input logic [15:0] off);
        return {7'b0, op, a, b, off};
    endfunction

    function automatic logic [31:0] er(input logic [2:0] op, input logic [2:0] a,
                                       input logic [2:0] b, input logic [2:0] d);
        return {7'b0, op, a, b, 13'b0, d};
    endfunction

    task automatic chk(input bit ok, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        int edges;
        for (int i = 0; i < 256; i++) mem[i] = 32'hDEAD_BEEF;
        mem[0]  = ei(3'd2, 3'd0, 3'd1, 16'd100);
        mem[1]  = ei(3'd2, 3'd0, 3'd2, 16'd101);
        mem[2]  = ei(3'd2, 3'd0, 3'd6, 16'd102);
        mem[3]  = ei(3'd2, 3'd0, 3'd7, 16'd103);
        mem[4]  = er(3'd0, 3'd1, 3'd2, 3'd3);
        mem[5]  = er(3'd1, 3'd1, 3'd2, 3'd4);
        mem[6]  = ei(3'd3, 3'd0, 3'd3, 16'd200);
        mem[7]  = ei(3'd3, 3'd0, 3'd4, 16'd201);
        mem[8]  = ei(3'd3, 3'd6, 3'd1, 16'(-8));
        mem[9]  = ei(3'd4, 3'd1, 3'd2, 16'd1);
        mem[10] = ei(3'd3, 3'd0, 3'd1, 16'd203);
        mem[11] = ei(3'd4, 3'd1, 3'd1, 16'd1);
        mem[12] = ei(3'd3, 3'd0, 3'd2, 16'd204);
        mem[13] = ei(3'd2, 3'd0, 3'd5, 16'd104);
        mem[14] = er(3'd0, 3'd5, 3'd7, 3'd5);
        mem[15] = ei(3'd4, 3'd5, 3'd0, 16'd1);
        mem[16] = ei(3'd4, 3'd0, 3'd0, 16'(-3));
        mem[17] = ei(3'd3, 3'd0, 3'd5, 16'd205);
        mem[18] = ei(3'd2, 3'd0, 3'd3, 16'd105);
        mem[19] = ei(3'd5, 3'd3, 3'd3, 16'd0);
        mem[20] = ei(3'd3, 3'd0, 3'd2, 16'd206);
        mem[21] = ei(3'd6, 3'd0, 3'd0, 16'd0);
        mem[22] = ei(3'd3, 3'd0, 3'd3, 16'd207);
        mem[23] = ei(3'd7, 3'd0, 3'd0, 16'd0);
        mem[24] = ei(3'd2, 3'd0, 3'd4, 16'd106);
        mem[25] = ei(3'd5, 3'd4, 3'd6, 16'd0);
        mem[26] = ei(3'd3, 3'd0, 3'd1, 16'd208);
        mem[27] = ei(3'd6, 3'd0, 3'd0, 16'd0);
        mem[28] = ei(3'd3, 3'd0, 3'd6, 16'd209);
        mem[29] = ei(3'd6, 3'd0, 3'd0, 16'd0);
        mem[100] = 32'd5;
        mem[101] = 32'hFFFF_FFF8;
        mem[102] = 32'd210;
        mem[103] = 32'hFFFF_FFFF;
        mem[104] = 32'd3;
        mem[105] = 32'd22;
        mem[106] = 32'd28;

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(pc == 0, "R1 reset pc", 32'(pc), 0);
        chk(instr_count == 0, "R1 reset count", instr_count, 0);
        chk(halted == 0, "R1 reset halted", 32'(halted), 0);
        rst = 1'b0;

        edges = 0;
        while (!halted && edges < 2000) begin
            @(posedge clk);
            edges++;
            @(negedge clk);
            if (edges == 2) chk(instr_count == 0, "R8 load not done at edge 2", instr_count, 0);
            if (edges == 3) begin
                chk(instr_count == 1, "R8 load done at edge 3", instr_count, 1);
                chk(pc == 1, "R8 pc after first load", 32'(pc), 1);
            end
        end
        chk(edges == 74, "R8 cycles to halt", 32'(edges), 74);
        chk(instr_count == 30, "R7 completed count incl. halt, noop R9", instr_count, 30);
        chk(pc == 30, "R6 pc past halt", 32'(pc), 30);

        for (int k = 0; k < 10; k++) begin
            chk(mem[EXPECT[k][39:32]] == EXPECT[k][31:0], tag_of(int'(EXPECT[k][39:32])),
                mem[EXPECT[k][39:32]], EXPECT[k][31:0]);
        end

        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (mem_we) chk(1'b0, "R6 store after halt", 1, 0);
        end
        chk(halted == 1 && pc == 30, "R6 halted and pc frozen", 32'(pc), 30);
        chk(instr_count == 30, "R6 count frozen", instr_count, 30);

        // second run: registers must be cleared by reset (r1 held 5)
        rst = 1'b1;
        mem[0] = ei(3'd3, 3'd0, 3'd1, 16'd210);
        mem[1] = ei(3'd6, 3'd0, 3'd0, 16'd0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(pc == 0 && halted == 0, "R1 reset after halt", 32'(pc), 0);
        chk(instr_count == 0, "R1 count cleared", instr_count, 0);
        rst = 1'b0;
        edges = 0;
        while (!halted && edges < 50) begin
            @(posedge clk);
            edges++;
            @(negedge clk);
        end
        chk(edges == 5, "R8 store+halt cycles", 32'(edges), 5);
        chk(mem[210] == 0, "R1 register cleared by reset", mem[210], 0);
        chk(instr_count == 2, "R7 second run count", instr_count, 2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule